// File: doc/BRIEF.md
# Floating-Point Fault Trap Classifier

This block sits at the end of a floating-point execution pipe. It takes the status flags of a finished operation and decides, before anything reaches the register file, whether the result may be written or whether the instruction must fault. When it faults, the write is suppressed, a trap request to vector 0x44 is raised and a 4-bit condition code records the reason. When nothing faults, the write goes ahead and the normal condition code produced by the arithmetic passes through unchanged.

A division by zero and an exponent overflow always fault. An exponent underflow faults only when the underflow-select mode bit is set. Two significance checks apply only to add and subtract: an exact zero result, and a normalisation shift of more than two hex digits. They fault only when the significance-enable mode bit is 1 and the no-significance-override bit is 0. A fixed priority decides which cause is reported when several are present. Results appear one clock after the input strobe.

Top module: `fpt_trap_classifier`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid, wr_en, trap_req, trap_loc and cc_out are all zero.
- R2: Every cycle with in_valid high produces exactly one cycle with out_valid high, one clock later; no input gives no output.
- R3: A zero divisor always traps with cc_out = 4'b0100 and wr_en low, whatever the mode bits are.
- R4: An exponent overflow with no zero divisor always traps. cc_out is 4'b0101 for a negative result (res_sign = 1) and 4'b0110 for a positive result.
- R5: When a zero divisor and an overflow are flagged together, the zero divisor code 4'b0100 is reported.
- R6: An exponent underflow traps only when mode_fz = 1 and neither R3 nor R4 applies. cc_out is 4'b1101 when negative and 4'b1110 when positive. With mode_fz = 0 the underflow has no effect.
- R7: With op_addsub = 1, mode_fs = 1 and mode_fn = 0, a zero result traps with cc_out = 4'b1000, provided R3, R4 and R6 do not apply. Under any other mode setting the zero result has no effect.
- R8: Under the same conditions as R7, shift_cnt > 2 traps with cc_out = 4'b1001 (negative) or 4'b1010 (positive). shift_cnt = 2 does not trap.
- R9: A zero result takes priority over an excess shift, and a selected underflow takes priority over both.
- R10: When no trap is taken, wr_en = 1, trap_req = 0 and cc_out equals cc_in. wr_en and trap_req are never high together.
- R11: The significance checks of R7 and R8 are ignored when op_addsub = 0.
- R12: trap_loc is 8'h44 while trap_req is high and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation status present this cycle |
| div_zero | input | 1 | Divisor was zero |
| char_ovf | input | 1 | Exponent overflow |
| char_unf | input | 1 | Exponent underflow |
| zero_res | input | 1 | Add/subtract produced an exact zero |
| shift_cnt | input | SHIFT_W | Post-normalisation shift in hex digits |
| res_sign | input | 1 | Result sign, 1 = negative |
| op_addsub | input | 1 | Operation was add or subtract |
| mode_fs | input | 1 | Significance-check enable |
| mode_fz | input | 1 | Underflow trap select |
| mode_fn | input | 1 | Significance-check override |
| cc_in | input | 4 | Normal condition code from the arithmetic |
| out_valid | output | 1 | Decision valid |
| wr_en | output | 1 | Result may be written to the registers |
| trap_req | output | 1 | Fault trap requested |
| trap_loc | output | 8 | Trap vector (0x44) while trapping, else 0 |
| cc_out | output | 4 | Fault code or passed-through condition code |

## Verification
The patterns first present each fault flag alone, with both result signs, to confirm each code. They then repeat the same flags with the mode bits flipped, which shows which faults are unconditional and which are selected by the mode bits. Pairs of flags raised in the same cycle show the priority order. A shift count of exactly two, set against three and above, marks the edge of the excess-shift threshold. The significance flags are also applied to operations other than add and subtract, to show they are ignored there. Back-to-back strobes and idle gaps show that each input yields exactly one decision.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

  localparam int NUM_FAULTS = 5;

  // Fault causes; numeric order is the priority order (1 = highest)
  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_DIVZ  = 3'd1,
    CAUSE_OVF   = 3'd2,
    CAUSE_UNF   = 3'd3,
    CAUSE_ZRES  = 3'd4,
    CAUSE_SHIFT = 3'd5
  } cause_e;

  localparam logic [3:0] CC_DIVZ     = 4'b0100;
  localparam logic [3:0] CC_OVF_NEG  = 4'b0101;
  localparam logic [3:0] CC_OVF_POS  = 4'b0110;
  localparam logic [3:0] CC_UNF_NEG  = 4'b1101;
  localparam logic [3:0] CC_UNF_POS  = 4'b1110;
  localparam logic [3:0] CC_ZRES     = 4'b1000;
  localparam logic [3:0] CC_SHF_NEG  = 4'b1001;
  localparam logic [3:0] CC_SHF_POS  = 4'b1010;

endpackage

// File: rtl/fpt_qualify.sv
// Gates each raw fault flag with the mode controls that select it.
// Output bit i corresponds to cause (i+1); bit 0 has highest priority.
module fpt_qualify
  import fpt_pkg::*;
#(
  parameter int SHIFT_W     = 4,
  parameter int SHIFT_LIMIT = 2
) (
  input  logic               div_zero,
  input  logic               char_ovf,
  input  logic               char_unf,
  input  logic               zero_res,
  input  logic [SHIFT_W-1:0] shift_cnt,
  input  logic               op_addsub,
  input  logic               mode_fs,
  input  logic               mode_fz,
  input  logic               mode_fn,
  output logic [NUM_FAULTS-1:0] fault_vec
);

  localparam logic [SHIFT_W-1:0] LIMIT_V = SHIFT_W'(SHIFT_LIMIT);

  logic sig_enable;
  logic shift_excess;

  always_comb begin
    sig_enable   = op_addsub & mode_fs & ~mode_fn;
    shift_excess = (shift_cnt > LIMIT_V);
    fault_vec    = '0;
    fault_vec[int'(CAUSE_DIVZ)  - 1] = div_zero;
    fault_vec[int'(CAUSE_OVF)   - 1] = char_ovf;
    fault_vec[int'(CAUSE_UNF)   - 1] = char_unf & mode_fz;
    fault_vec[int'(CAUSE_ZRES)  - 1] = zero_res & sig_enable;
    fault_vec[int'(CAUSE_SHIFT) - 1] = shift_excess & sig_enable;
  end

endmodule

// File: rtl/fpt_prio.sv
// Fixed-priority pick of the winning fault cause.
module fpt_prio
  import fpt_pkg::*;
(
  input  logic [NUM_FAULTS-1:0] fault_vec,
  output cause_e                cause,
  output logic                  any_fault
);

  always_comb begin
    cause = CAUSE_NONE;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (fault_vec[i]) begin
        cause = cause_e'(3'(i + 1));
      end
    end
    any_fault = |fault_vec;
  end

endmodule

// File: rtl/fpt_encode.sv
// Maps the winning cause and result sign onto a condition code.
module fpt_encode
  import fpt_pkg::*;
(
  input  cause_e     cause,
  input  logic       res_sign,
  input  logic [3:0] cc_in,
  output logic [3:0] cc_next
);

  always_comb begin
    unique case (cause)
      CAUSE_DIVZ:  cc_next = CC_DIVZ;
      CAUSE_OVF:   cc_next = res_sign ? CC_OVF_NEG : CC_OVF_POS;
      CAUSE_UNF:   cc_next = res_sign ? CC_UNF_NEG : CC_UNF_POS;
      CAUSE_ZRES:  cc_next = CC_ZRES;
      CAUSE_SHIFT: cc_next = res_sign ? CC_SHF_NEG : CC_SHF_POS;
      default:     cc_next = cc_in;
    endcase
  end

endmodule

// File: rtl/fpt_trap_classifier.sv
module fpt_trap_classifier
  import fpt_pkg::*;
#(
  parameter int          SHIFT_W     = 4,
  parameter int          SHIFT_LIMIT = 2,
  parameter int          VEC_W       = 8,
  parameter logic [7:0]  TRAP_VEC    = 8'h44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               div_zero,
  input  logic               char_ovf,
  input  logic               char_unf,
  input  logic               zero_res,
  input  logic [SHIFT_W-1:0] shift_cnt,
  input  logic               res_sign,
  input  logic               op_addsub,
  input  logic               mode_fs,
  input  logic               mode_fz,
  input  logic               mode_fn,
  input  logic [3:0]         cc_in,
  output logic               out_valid,
  output logic               wr_en,
  output logic               trap_req,
  output logic [VEC_W-1:0]   trap_loc,
  output logic [3:0]         cc_out
);

  logic [NUM_FAULTS-1:0] fault_vec;
  cause_e                cause;
  logic                  any_fault;
  logic [3:0]            cc_next;

  logic                  vld_q;
  logic                  trap_q;
  logic [3:0]            cc_q;
  logic                  vld_d;
  logic                  trap_d;
  logic [3:0]            cc_d;

  fpt_qualify #(
    .SHIFT_W     (SHIFT_W),
    .SHIFT_LIMIT (SHIFT_LIMIT)
  ) u_qualify (
    .div_zero  (div_zero),
    .char_ovf  (char_ovf),
    .char_unf  (char_unf),
    .zero_res  (zero_res),
    .shift_cnt (shift_cnt),
    .op_addsub (op_addsub),
    .mode_fs   (mode_fs),
    .mode_fz   (mode_fz),
    .mode_fn   (mode_fn),
    .fault_vec (fault_vec)
  );

  fpt_prio u_prio (
    .fault_vec (fault_vec),
    .cause     (cause),
    .any_fault (any_fault)
  );

  fpt_encode u_encode (
    .cause    (cause),
    .res_sign (res_sign),
    .cc_in    (cc_in),
    .cc_next  (cc_next)
  );

  // Next-state: decision fields load only on a strobe (clock enable)
  always_comb begin
    vld_d  = in_valid;
    trap_d = trap_q;
    cc_d   = cc_q;
    if (in_valid) begin
      trap_d = any_fault;
      cc_d   = cc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      trap_q <= 1'b0;
      cc_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      trap_q <= trap_d;
      cc_q   <= cc_d;
    end
  end

  always_comb begin
    out_valid = vld_q;
    wr_en     = vld_q & ~trap_q;
    trap_req  = vld_q & trap_q;
    trap_loc  = trap_req ? VEC_W'(TRAP_VEC) : '0;
    cc_out    = vld_q ? cc_q : 4'b0000;
  end

endmodule

// File: rtl/fpt_trap_chk.sv
module fpt_trap_chk #(
  parameter int          SHIFT_W     = 4,
  parameter int          SHIFT_LIMIT = 2,
  parameter int          VEC_W       = 8,
  parameter logic [7:0]  TRAP_VEC    = 8'h44
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               div_zero,
  input logic               char_ovf,
  input logic               char_unf,
  input logic               zero_res,
  input logic [SHIFT_W-1:0] shift_cnt,
  input logic               res_sign,
  input logic               op_addsub,
  input logic               mode_fs,
  input logic               mode_fz,
  input logic               mode_fn,
  input logic [3:0]         cc_in,
  input logic               out_valid,
  input logic               wr_en,
  input logic               trap_req,
  input logic [VEC_W-1:0]   trap_loc,
  input logic [3:0]         cc_out
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && div_zero) |=> (trap_req && !wr_en && cc_out == 4'b0100));

  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !div_zero && char_ovf) |=> (trap_req && cc_out[3:2] == 2'b01));

  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !div_zero && !char_ovf && char_unf && mode_fz)
      |=> (trap_req && cc_out[3:2] == 2'b11));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && trap_req));

  a_r12_vector: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_loc == VEC_W'(TRAP_VEC)));

endmodule

bind fpt_trap_classifier fpt_trap_chk #(
  .SHIFT_W     (SHIFT_W),
  .SHIFT_LIMIT (SHIFT_LIMIT),
  .VEC_W       (VEC_W),
  .TRAP_VEC    (TRAP_VEC)
) u_chk (.*);

// File: tb/fpt_trap_classifier_test.sv
module fpt_trap_classifier_test;

  logic       clk;
  logic       rst_n;
  logic       in_valid, div_zero, char_ovf, char_unf, zero_res;
  logic [3:0] shift_cnt;
  logic       res_sign, op_addsub, mode_fs, mode_fz, mode_fn;
  logic [3:0] cc_in;
  logic       out_valid, wr_en, trap_req;
  logic [7:0] trap_loc;
  logic [3:0] cc_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  fpt_trap_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .div_zero(div_zero),
    .char_ovf(char_ovf), .char_unf(char_unf), .zero_res(zero_res),
    .shift_cnt(shift_cnt), .res_sign(res_sign), .op_addsub(op_addsub),
    .mode_fs(mode_fs), .mode_fz(mode_fz), .mode_fn(mode_fn), .cc_in(cc_in),
    .out_valid(out_valid), .wr_en(wr_en), .trap_req(trap_req),
    .trap_loc(trap_loc), .cc_out(cc_out)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Reference: {wr_en, trap_req, trap_loc, cc_out}
  function automatic logic [13:0] model(bit dz, bit ov, bit un, bit zr,
      logic [3:0] sh, bit sg, bit as, bit fs, bit fz, bit fn, logic [3:0] cc);
    bit sig = as && fs && !fn;
    logic [3:0] code;
    bit t = 1;
    if (dz)                 code = 4'b0100;
    else if (ov)            code = sg ? 4'b0101 : 4'b0110;
    else if (un && fz)      code = sg ? 4'b1101 : 4'b1110;
    else if (sig && zr)     code = 4'b1000;
    else if (sig && sh > 2) code = sg ? 4'b1001 : 4'b1010;
    else begin code = cc; t = 0; end
    return {~t, t, (t ? 8'h44 : 8'h00), code};
  endfunction

  task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got wr=%b trap=%b loc=%h cc=%b, expected wr=%b trap=%b loc=%h cc=%b",
               tag, act[13], act[12], act[11:4], act[3:0],
               exp[13], exp[12], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic send(string tag, bit dz, bit ov, bit un, bit zr,
      logic [3:0] sh, bit sg, bit as, bit fs, bit fz, bit fn, logic [3:0] cc);
    @(negedge clk);
    in_valid = 1; div_zero = dz; char_ovf = ov; char_unf = un; zero_res = zr;
    shift_cnt = sh; res_sign = sg; op_addsub = as; mode_fs = fs;
    mode_fz = fz; mode_fn = fn; cc_in = cc;
    exp_q.push_back(model(dz, ov, un, zr, sh, sg, as, fs, fz, fn, cc));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      div_zero = 1; char_ovf = 1;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected output, got out_valid=1, expected 0");
      end else begin
        check(tag_q.pop_front(), {wr_en, trap_req, trap_loc, cc_out}, exp_q.pop_front());
      end
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; div_zero = 0; char_ovf = 0; char_unf = 0;
    zero_res = 0; shift_cnt = 0; res_sign = 0; op_addsub = 0;
    mode_fs = 0; mode_fz = 0; mode_fn = 0; cc_in = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, wr_en, trap_req, trap_loc, cc_out}, 15'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {out_valid, wr_en, trap_req, trap_loc, cc_out}, 15'h0);

    //   tag                        dz ov un zr sh sg as fs fz fn cc
    send("R3 zero divisor",          1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'h3);
    send("R3 zero divisor modes",    1, 0, 1, 1, 7, 1, 1, 1, 1, 0, 4'h3);
    send("R4 overflow neg",          0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 4'h0);
    send("R4 overflow pos modes",    0, 1, 1, 0, 0, 0, 1, 1, 1, 1, 4'h0);
    send("R5 divz over ovf",         1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 4'h0);
    idle(2);
    send("R6 underflow neg",         0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 4'h2);
    send("R6 underflow pos",         0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 4'h2);
    send("R6 underflow masked",      0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 4'h9);
    send("R6 ovf over underflow",    0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 4'h0);
    send("R7 zero result",           0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 4'h5);
    send("R7 zero res fs=0",         0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 4'h5);
    send("R7 zero res fn=1",         0, 0, 0, 1, 0, 0, 1, 1, 0, 1, 4'h6);
    idle(1);
    send("R8 shift 3 neg",           0, 0, 0, 0, 3, 1, 1, 1, 0, 0, 4'h1);
    send("R8 shift 15 pos",          0, 0, 0, 0, 15, 0, 1, 1, 0, 0, 4'h1);
    send("R8 shift 2 boundary",      0, 0, 0, 0, 2, 1, 1, 1, 0, 0, 4'hC);
    send("R8 shift fn=1",            0, 0, 0, 0, 5, 1, 1, 1, 0, 1, 4'hC);
    send("R9 zero over shift",       0, 0, 0, 1, 6, 1, 1, 1, 0, 0, 4'h0);
    send("R9 underflow over signif", 0, 0, 1, 1, 6, 0, 1, 1, 1, 0, 4'h0);
    send("R10 clean pass",           0, 0, 0, 0, 1, 0, 1, 1, 1, 0, 4'hA);
    send("R10 clean pass other",     0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 4'h7);
    send("R11 non addsub zero",      0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 4'hE);
    send("R11 non addsub shift",     0, 0, 0, 0, 9, 1, 0, 1, 0, 0, 4'hB);
    send("R12 vector on trap",       0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'h0);
    idle(3);
    check("R2 all outputs seen", {13'h0, exp_q.size() == 0}, 14'h1);
    check("R2 idle no output", {out_valid, wr_en, trap_req, trap_loc, cc_out}, 15'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule